// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block resolves read-after-write data hazards for a five-stage in-order integer pipeline. It looks at the source register numbers of the instruction in decode and of the instruction in execute. It compares them with the destination registers and write enables of the three instructions ahead, which sit in the ID/EX, EX/MEM and MEM/WB pipeline registers. From this it drives two operand-select codes for the ALU input multiplexers, one per operand. It also drives a set of stall outputs that freeze the PC and the IF/ID register and turn the instruction entering ID/EX into a nop.

With forwarding enabled, results are bypassed from EX/MEM or MEM/WB. A stall is raised only when a load in execute is followed at once by an instruction in decode that reads its destination. The stall lasts exactly one cycle, and the operand is then taken from MEM/WB. With forwarding disabled, every operand comes from the register file. A dependent instruction is held in decode until its producer reaches writeback. Because the register file writes before it reads within a cycle, the value is then already visible. All outputs are combinational functions of the current pipeline-register contents.

Top module: `hz_forward_unit`

## Requirements
- R1: When an EX source matches no qualifying producer, its select is 2'b00 (register file value read in decode).
- R2: When an EX source equals the EX/MEM destination, and that stage writes a register, the select is 2'b10 (EX/MEM ALU result).
- R3: When an EX source equals the MEM/WB destination, that stage writes a register, and EX/MEM does not match, the select is 2'b01 (MEM/WB value).
- R4: When both EX/MEM and MEM/WB match the same source, the select is 2'b10, since the younger producer holds the newer value.
- R5: A producer qualifies only when its write enable is 1 and its destination is not register 0. Reading register 0 is therefore never forwarded or stalled.
- R6: With forwarding enabled, a load in execute whose destination matches either decode source sets bubble=1, pc_we=0 and ifid_we=0. A matching non-load producer in execute, or any producer further ahead, causes no stall.
- R7: In every cycle, pc_we equals ifid_we and bubble is their inverse. With no hazard, pc_we=1, ifid_we=1 and bubble=0.
- R8: With forwarding disabled (fwd_en=0), both selects are 2'b00 for every input.
- R9: With forwarding disabled, a qualifying producer in execute or in EX/MEM that matches either decode source raises the stall. A matching producer in MEM/WB does not.
- R10: Over a running instruction stream, the following hold:
  - A load followed directly by its consumer costs one bubble with forwarding, after which the consumer uses select 2'b01. The same pair costs two bubbles without forwarding.
  - An ALU producer followed directly by its consumer costs no bubble with forwarding. It costs two bubbles without forwarding, and one bubble when a single independent instruction lies between them.
  - A consumer three positions behind its producer uses select 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_en | input | 1 | 1 = bypass and load-use interlock; 0 = stall-only resolution |
| id_rs1 | input | AW | First source register of the instruction in decode |
| id_rs2 | input | AW | Second source register of the instruction in decode |
| ex_rs1 | input | AW | First source register of the instruction in execute |
| ex_rs2 | input | AW | Second source register of the instruction in execute |
| ex_rd | input | AW | Destination register held in ID/EX |
| ex_regwr | input | 1 | Register write enable held in ID/EX |
| ex_memrd | input | 1 | Instruction in execute is a load |
| mem_rd | input | AW | Destination register held in EX/MEM |
| mem_regwr | input | 1 | Register write enable held in EX/MEM |
| wb_rd | input | AW | Destination register held in MEM/WB |
| wb_regwr | input | 1 | Register write enable held in MEM/WB |
| fwd_a | output | 2 | Select for ALU operand A (00 file, 10 EX/MEM, 01 MEM/WB) |
| fwd_b | output | 2 | Select for ALU operand B (same encoding) |
| pc_we | output | 1 | PC update enable, 0 while stalling |
| ifid_we | output | 1 | IF/ID update enable, 0 while stalling |
| bubble | output | 1 | Zero the control fields entering ID/EX |

## Verification
The unit holds no state. A wrong priority or a missing qualifier therefore shows at once, in the same cycle, as a wrong select code or a wrong stall level for the offending register combination. A small register space is swept over every combination of source numbers, destinations, write enables, load flag and mode, and each output is compared with arithmetic expectations. A stall that is off by one cycle, or a bypass taken from the wrong stage, would only show over time as a wrong bubble count or a wrong select once the consumer reaches execute. For that reason, short instruction streams are also run through a bench-side pipeline model, and their stall counts are checked.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
  // ALU operand source codes; the datapath mux decodes these values
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } opnd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
`timescale 1ns/1ps
// One comparator: a source register depends on a producer that really writes
module hz_src_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          prod_we,
  input  logic [AW-1:0] prod_rd,
  output logic          hit
);
  always_comb begin
    hit = prod_we && (prod_rd != '0) && (prod_rd == src);
  end
endmodule

// File: rtl/hz_opnd_sel.sv
`timescale 1ns/1ps
// Per-operand bypass selection with newest-producer priority
module hz_opnd_sel
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          fwd_en,
  input  logic [AW-1:0] src,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_rd,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_rd,
  output logic [1:0]    sel
);
  logic      hit_mem;
  logic      hit_wb;
  opnd_sel_e sel_e;

  hz_src_match #(.AW(AW)) u_m_mem (
    .src(src), .prod_we(mem_we), .prod_rd(mem_rd), .hit(hit_mem)
  );
  hz_src_match #(.AW(AW)) u_m_wb (
    .src(src), .prod_we(wb_we), .prod_rd(wb_rd), .hit(hit_wb)
  );

  always_comb begin
    if (!fwd_en)      sel_e = SEL_RF;
    else if (hit_mem) sel_e = SEL_MEM;
    else if (hit_wb)  sel_e = SEL_WB;
    else              sel_e = SEL_RF;
    sel = sel_e;
  end
endmodule

// File: rtl/hz_interlock.sv
`timescale 1ns/1ps
// Decode-stage interlock: load-use in bypass mode, wait-for-writeback otherwise
module hz_interlock #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic               fwd_en,
  input  logic [NSRC*AW-1:0] id_src,
  input  logic               ex_we,
  input  logic               ex_load,
  input  logic [AW-1:0]      ex_rd,
  input  logic               mem_we,
  input  logic [AW-1:0]      mem_rd,
  output logic               stall
);
  logic [NSRC-1:0] hit_ex;
  logic [NSRC-1:0] hit_mem;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_src_match #(.AW(AW)) u_m_ex (
      .src(id_src[g*AW +: AW]), .prod_we(ex_we), .prod_rd(ex_rd), .hit(hit_ex[g])
    );
    hz_src_match #(.AW(AW)) u_m_mem (
      .src(id_src[g*AW +: AW]), .prod_we(mem_we), .prod_rd(mem_rd), .hit(hit_mem[g])
    );
  end

  logic load_use;
  logic wait_wb;

  always_comb begin
    load_use = ex_load && (|hit_ex);
    // write-then-read register file: a producer in WB needs no wait
    wait_wb  = (|hit_ex) || (|hit_mem);
    stall    = fwd_en ? load_use : wait_wb;
  end
endmodule

// File: rtl/hz_forward_unit.sv
`timescale 1ns/1ps
module hz_forward_unit #(
  parameter int AW = 5
) (
  input  logic          fwd_en,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_regwr,
  input  logic          ex_memrd,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_regwr,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_regwr,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          bubble
);
  localparam int NSRC = 2;

  logic [NSRC*AW-1:0] ex_src;
  logic [NSRC*AW-1:0] id_src;
  logic [NSRC*2-1:0]  sel_vec;
  logic               stall;

  assign ex_src = {ex_rs2, ex_rs1};
  assign id_src = {id_rs2, id_rs1};

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    hz_opnd_sel #(.AW(AW)) u_sel (
      .fwd_en (fwd_en),
      .src    (ex_src[g*AW +: AW]),
      .mem_we (mem_regwr),
      .mem_rd (mem_rd),
      .wb_we  (wb_regwr),
      .wb_rd  (wb_rd),
      .sel    (sel_vec[g*2 +: 2])
    );
  end

  hz_interlock #(.AW(AW), .NSRC(NSRC)) u_lock (
    .fwd_en  (fwd_en),
    .id_src  (id_src),
    .ex_we   (ex_regwr),
    .ex_load (ex_memrd),
    .ex_rd   (ex_rd),
    .mem_we  (mem_regwr),
    .mem_rd  (mem_rd),
    .stall   (stall)
  );

  always_comb begin
    fwd_a   = sel_vec[1:0];
    fwd_b   = sel_vec[3:2];
    pc_we   = !stall;
    ifid_we = !stall;
    bubble  = stall;
  end
endmodule

// File: rtl/hz_forward_unit_chk.sv
`timescale 1ns/1ps
module hz_forward_unit_chk #(
  parameter int AW = 5
) (
  input logic          fwd_en,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic [AW-1:0] ex_rd,
  input logic          ex_regwr,
  input logic          ex_memrd,
  input logic [AW-1:0] mem_rd,
  input logic          mem_regwr,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          bubble
);
  always_comb begin
    a_r2_sel_code_legal: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
      else $error("illegal select code");
    a_r4_mem_stage_wins: assert (!(fwd_en && mem_regwr && mem_rd != '0 && mem_rd == ex_rs1)
                                 || fwd_a == 2'b10)
      else $error("EX/MEM match not selected");
    a_r5_reg0_not_bypassed: assert ((ex_rs1 != '0 || fwd_a == 2'b00) &&
                                    (ex_rs2 != '0 || fwd_b == 2'b00))
      else $error("register 0 bypassed");
    a_r6_load_use_stall: assert (!(fwd_en && ex_memrd && ex_regwr && ex_rd != '0 && ex_rd == id_rs1)
                                 || (bubble && !pc_we && !ifid_we))
      else $error("load-use not stalled");
    a_r7_stall_outputs_agree: assert (pc_we == ifid_we && bubble == !pc_we)
      else $error("stall outputs disagree");
    a_r8_no_bypass_mode: assert (fwd_en || (fwd_a == 2'b00 && fwd_b == 2'b00))
      else $error("bypass in stall-only mode");
  end
endmodule

bind hz_forward_unit hz_forward_unit_chk #(.AW(AW)) u_chk (
  .fwd_en(fwd_en), .id_rs1(id_rs1), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
  .ex_rd(ex_rd), .ex_regwr(ex_regwr), .ex_memrd(ex_memrd),
  .mem_rd(mem_rd), .mem_regwr(mem_regwr), .fwd_a(fwd_a), .fwd_b(fwd_b),
  .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble)
);

// File: tb/hz_forward_unit_tb.sv
`timescale 1ns/100ps
module hz_forward_unit_tb;
  localparam int AW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          fwd_en;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic          ex_regwr, ex_memrd, mem_regwr, wb_regwr;
  logic [1:0]    fwd_a, fwd_b;
  logic          pc_we, ifid_we, bubble;

  int checks = 0;
  int errors = 0;

  hz_forward_unit #(.AW(AW)) u_dut (
    .fwd_en(fwd_en), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
    .ex_regwr(ex_regwr), .ex_memrd(ex_memrd),
    .mem_rd(mem_rd), .mem_regwr(mem_regwr),
    .wb_rd(wb_rd), .wb_regwr(wb_regwr),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic qual(input logic we, input logic [AW-1:0] rd, input logic [AW-1:0] s);
    return we && rd != 0 && rd == s;
  endfunction

  // Expected select: R8 off-mode, R2/R4 EX/MEM first, R3 MEM/WB, R1/R5 file
  function automatic int exp_sel(input logic [AW-1:0] s);
    if (!fwd_en) return 0;
    if (qual(mem_regwr, mem_rd, s)) return 2;
    if (qual(wb_regwr, wb_rd, s)) return 1;
    return 0;
  endfunction

  function automatic string sel_req(input logic [AW-1:0] s);
    if (!fwd_en) return "R8";
    if (qual(mem_regwr, mem_rd, s) && qual(wb_regwr, wb_rd, s)) return "R4";
    if (qual(mem_regwr, mem_rd, s)) return "R2";
    if (qual(wb_regwr, wb_rd, s)) return "R3";
    if ((mem_rd == s) || (wb_rd == s)) return "R5";
    return "R1";
  endfunction

  function automatic int exp_stall();
    logic hx, hm;
    hx = qual(ex_regwr, ex_rd, id_rs1) || qual(ex_regwr, ex_rd, id_rs2);
    hm = qual(mem_regwr, mem_rd, id_rs1) || qual(mem_regwr, mem_rd, id_rs2);
    if (fwd_en) return int'(ex_memrd && hx);
    return int'(hx || hm);
  endfunction

  task automatic check_all();
    int st;
    string rq;
    st = exp_stall();
    rq = (st == 0) ? "R7" : (fwd_en ? "R6" : "R9");
    chk(sel_req(ex_rs1), "fwd_a", fwd_a, exp_sel(ex_rs1));
    chk(sel_req(ex_rs2), "fwd_b", fwd_b, exp_sel(ex_rs2));
    chk(rq, "bubble", bubble, st);
    chk(rq, "pc_we", pc_we, 1 - st);
    chk("R7", "ifid_we", ifid_we, 1 - st);
  endtask

  task automatic sweep();
    for (int v = 0; v < (1 << 19); v++) begin
      id_rs1 = v[1:0];  id_rs2 = v[3:2];
      ex_rs1 = v[5:4];  ex_rs2 = v[7:6];
      ex_rd  = v[9:8];  mem_rd = v[11:10]; wb_rd = v[13:12];
      ex_regwr = v[14]; ex_memrd = v[15];
      mem_regwr = v[16]; wb_regwr = v[17];
      fwd_en = v[18];
      #1;
      check_all();
      #1;
    end
  endtask

  // Bench-side pipeline model for R10
  typedef struct packed {
    logic [AW-1:0] rd, rs1, rs2;
    logic          we, ld, cons;
  } ins_t;

  task automatic drive(input ins_t id_i, input ins_t ex_i, input ins_t mm_i, input ins_t wb_i);
    id_rs1 = id_i.rs1; id_rs2 = id_i.rs2;
    ex_rs1 = ex_i.rs1; ex_rs2 = ex_i.rs2; ex_rd = ex_i.rd;
    ex_regwr = ex_i.we; ex_memrd = ex_i.ld;
    mem_rd = mm_i.rd; mem_regwr = mm_i.we;
    wb_rd = wb_i.rd; wb_regwr = wb_i.we;
  endtask

  task automatic run_seq(input string tag, input logic is_load, input int gap,
                         input logic fen, input int exp_st, input int exp_s);
    ins_t prog [8];
    ins_t nop, s_id, s_ex, s_mm, s_wb;
    int pc, stalls, sel_seen;
    nop = '0;
    for (int i = 0; i < 8; i++) prog[i] = nop;
    prog[0] = '{rd: 2'd1, rs1: 2'd2, rs2: 2'd3, we: 1'b1, ld: is_load, cons: 1'b0};
    prog[1 + gap] = '{rd: 2'd2, rs1: 2'd1, rs2: 2'd3, we: 1'b1, ld: 1'b0, cons: 1'b1};
    s_id = prog[0]; s_ex = nop; s_mm = nop; s_wb = nop; pc = 1;
    stalls = 0; sel_seen = -1;
    fwd_en = fen;
    drive(s_id, s_ex, s_mm, s_wb);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (bubble) stalls++;
      if (s_ex.cons) sel_seen = fwd_a;
      s_wb = s_mm; s_mm = s_ex;
      if (bubble) s_ex = nop;
      else begin
        s_ex = s_id;
        s_id = (pc < 8) ? prog[pc] : nop;
        pc++;
      end
      drive(s_id, s_ex, s_mm, s_wb);
    end
    chk("R10", {tag, " stall cycles"}, stalls, exp_st);
    chk("R10", {tag, " consumer select"}, sel_seen, exp_s);
  endtask

  task automatic run_all();
    // idle state: nothing writes, no hazard (R1, R7)
    fwd_en = 1'b1; id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0;
    ex_rd = 0; mem_rd = 0; wb_rd = 0;
    ex_regwr = 0; ex_memrd = 0; mem_regwr = 0; wb_regwr = 0;
    #1;
    chk("R1", "idle fwd_a", fwd_a, 0);
    chk("R1", "idle fwd_b", fwd_b, 0);
    chk("R7", "idle pc_we", pc_we, 1);
    chk("R7", "idle bubble", bubble, 0);
    run_seq("load+use fwd",      1'b1, 0, 1'b1, 1, 1);
    run_seq("load gap1 fwd",     1'b1, 1, 1'b1, 0, 1);
    run_seq("alu+use fwd",       1'b0, 0, 1'b1, 0, 2);
    run_seq("alu gap1 fwd",      1'b0, 1, 1'b1, 0, 1);
    run_seq("alu gap2 fwd",      1'b0, 2, 1'b1, 0, 0);
    run_seq("load+use nofwd",    1'b1, 0, 1'b0, 2, 0);
    run_seq("alu+use nofwd",     1'b0, 0, 1'b0, 2, 0);
    run_seq("alu gap1 nofwd",    1'b0, 1, 1'b0, 1, 0);
    run_seq("alu gap2 nofwd",    1'b0, 2, 1'b0, 0, 0);
    #0.5;
    sweep();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule